// File: doc/BRIEF.md
# Control and Status Register Bank with Dual-Clock Crossing

This block sits between a slow host bus and a fast streaming engine. A simple word-oriented bus, of the kind a block-RAM controller presents, runs in the slow domain (nominally 100 MHz). The host uses it to write an engine reset bit, a run enable, a 12-bit frame length, a 12-bit repeat count and a 16-bit address wrap point. It reads back a fixed identification word and a completion flag. All registers live in the slow domain. The engine runs in a domain four times faster (nominally 400 MHz) and sees every control value through a synchronizer.

The two single-bit controls each cross through their own two-flop synchronizer. The three numeric fields travel together as one bundle. Any write to one of them flips an update toggle. The fast side synchronizes that toggle and captures the whole bundle on its edge, so the engine never sees a mix of old and new bits. The engine's completion flag returns through a two-flop synchronizer before it can be read.

A read is accepted when the enable is high and the write strobe is low. The read data is registered and appears one bus clock later. Each domain has its own synchronous active-low reset.

Top module: `csr_cdc_bank`

## Requirements
- R1: After bus reset, all writable registers read zero and bus_rdata is zero.
- R2: A read of byte offset 0x00 returns the ID_VALUE parameter (default 0x5C5B0001). Writes to offsets 0x00 and 0x20 leave every readable value unchanged.
- R3: Offset 0x04 holds the engine reset in bit 0 and the run enable in bit 4. A write stores only those two bits. Reads of offset 0x04 return all other bits as zero.
- R4: A write stores the frame length from bits [11:0] at offset 0x08, the repeat count from bits [11:0] at offset 0x0C, and the wrap address from bits [15:0] at offset 0x10. A read of each offset returns its field zero-extended.
- R5: A read of any byte offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x20 returns zero. A write to such an offset changes no readable value.
- R6: Read data is registered. It is valid one bus clock after the read request and holds until the next read request.
- R7: eng_reset and eng_go follow offset 0x04 bits 0 and 4 within two bus clock periods of the write.
- R8: eng_blk_len, eng_iter_cnt and eng_wrap_addr follow the stored fields within two bus clock periods of the last write. They change only all at once, from one consistent bundle.
- R9: Offset 0x20 bit 0 shows the level of eng_done after two bus clock edges of synchronization. The other bits read zero.
- R10: While eng_rst_n is low, all engine-side outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Slow host-bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| bus_en | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_clk | input | 1 | Fast engine clock |
| eng_rst_n | input | 1 | Synchronous active-low reset, engine domain |
| eng_done | input | 1 | Completion level from the engine |
| eng_reset | output | 1 | Engine reset control |
| eng_go | output | 1 | Engine run enable |
| eng_blk_len | output | 12 | Frame length in beats |
| eng_iter_cnt | output | 12 | Frame repeat count |
| eng_wrap_addr | output | 16 | Address wrap point |

## Verification
The fast side can still be capturing one configuration update when the host commits the next one. The bench provokes this with back-to-back writes to the frame length, repeat count and wrap address on consecutive bus clocks. It then requires all three engine outputs to settle on the final values. An in-module assertion checks that every capture copies the bundle exactly. The completion flag can also change while its register is being read. The bench toggles eng_done and then requires the read-back to show the new level after the synchronizer delay, with no false value in between.

// File: rtl/csr_cdc_pkg.sv
// Package: shared widths, byte offsets, register-select type and the
// configuration bundle that crosses into the engine domain as one unit.
package csr_cdc_pkg;
    localparam int DATA_W = 32;
    localparam int BLK_W  = 12;
    localparam int ITER_W = 12;
    localparam int WRAP_W = 16;

    localparam int OFS_ID   = 'h00;
    localparam int OFS_CTRL = 'h04;
    localparam int OFS_BLK  = 'h08;
    localparam int OFS_ITER = 'h0C;
    localparam int OFS_WRAP = 'h10;
    localparam int OFS_DONE = 'h20;

    localparam int CTRL_RST_BIT = 0;
    localparam int CTRL_GO_BIT  = 4;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_ID, SEL_CTRL, SEL_BLK, SEL_ITER, SEL_WRAP, SEL_DONE
    } reg_sel_e;

    typedef struct packed {
        logic [WRAP_W-1:0] wrap;
        logic [ITER_W-1:0] iter;
        logic [BLK_W-1:0]  blk;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/csr_sync_bit.sv
// Module: csr_sync_bit
// Multi-flop level synchronizer into the clock domain of clk.
// Assumes: d is a level held far longer than STAGES cycles of clk.
// Reset: synchronous active-low, clears every stage to zero.
module csr_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/csr_cfg_sync.sv
// Module: csr_cfg_sync
// Moves a quasi-static multi-bit bundle into the destination domain.
// The source flips src_tgl on the same edge it updates src_data. This
// side synchronizes the toggle and captures the whole bundle on its edge.
// Assumes: src_data is stable for at least SYNC_STAGES+1 destination
// cycles after each toggle; the source clock is slower than dst_clk.
// Reset: synchronous active-low; the captured bundle clears to zero.
module csr_cfg_sync #(
    parameter int W           = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    input  logic [W-1:0] src_data,
    input  logic         src_tgl,
    output logic [W-1:0] dst_data
);
    logic tgl_sync;
    logic tgl_seen;
    logic cap;

    csr_sync_bit #(.STAGES(SYNC_STAGES)) u_tgl_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d     (src_tgl),
        .q     (tgl_sync)
    );

    assign cap = tgl_sync ^ tgl_seen;

    // Remember the last toggle level that was acted on.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) tgl_seen <= 1'b0;
        else            tgl_seen <= tgl_sync;
    end

    // Capture the full bundle on each toggle edge.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) dst_data <= '0;
        else if (cap)   dst_data <= src_data;
    end

    // R8
    cap_coherent_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        cap |=> (dst_data == $past(src_data)));

    // R8
    cap_spacing_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        cap |=> !cap);

    // R10
    cfg_reset_chk: assert property (@(posedge dst_clk)
        !dst_rst_n |=> (dst_data == '0));
endmodule

// File: rtl/csr_regs.sv
// Module: csr_regs
// Bus-side register storage: address decode, write handling, read mux
// and the update toggle that marks each change of the configuration bundle.
// Assumes: done_sync is already synchronized into clk.
// Reset: synchronous active-low; every stored field, toggle and read
// register clears to zero.
module csr_regs
    import csr_cdc_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] ID_VALUE = 32'h5C5B_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              done_sync,
    output logic              ctrl_rst,
    output logic              ctrl_go,
    output cfg_t              cfg,
    output logic              cfg_tgl
);
    reg_sel_e          sel;
    logic              wr_fire;
    logic              rd_fire;
    logic              cfg_wr;
    logic [DATA_W-1:0] rd_mux;

    // Decode the byte offset into a register select.
    always_comb begin
        if      (addr == ADDR_W'(OFS_ID))   sel = SEL_ID;
        else if (addr == ADDR_W'(OFS_CTRL)) sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFS_BLK))  sel = SEL_BLK;
        else if (addr == ADDR_W'(OFS_ITER)) sel = SEL_ITER;
        else if (addr == ADDR_W'(OFS_WRAP)) sel = SEL_WRAP;
        else if (addr == ADDR_W'(OFS_DONE)) sel = SEL_DONE;
        else                                sel = SEL_NONE;
    end

    assign wr_fire = en & we;
    assign rd_fire = en & ~we;
    assign cfg_wr  = wr_fire & ((sel == SEL_BLK) | (sel == SEL_ITER) | (sel == SEL_WRAP));

    // Store the two control bits on a write to the control offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_rst <= 1'b0;
            ctrl_go  <= 1'b0;
        end else if (wr_fire && sel == SEL_CTRL) begin
            ctrl_rst <= wdata[CTRL_RST_BIT];
            ctrl_go  <= wdata[CTRL_GO_BIT];
        end
    end

    // Store the numeric fields and flip the toggle on every change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            cfg_tgl <= 1'b0;
        end else if (cfg_wr) begin
            cfg_tgl <= ~cfg_tgl;
            case (sel)
                SEL_BLK:  cfg.blk  <= wdata[BLK_W-1:0];
                SEL_ITER: cfg.iter <= wdata[ITER_W-1:0];
                SEL_WRAP: cfg.wrap <= wdata[WRAP_W-1:0];
                default:  cfg      <= cfg;
            endcase
        end
    end

    // Select the readable value for the decoded offset.
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_ID: rd_mux = ID_VALUE;
            SEL_CTRL: begin
                rd_mux[CTRL_RST_BIT] = ctrl_rst;
                rd_mux[CTRL_GO_BIT]  = ctrl_go;
            end
            SEL_BLK:  rd_mux[BLK_W-1:0]  = cfg.blk;
            SEL_ITER: rd_mux[ITER_W-1:0] = cfg.iter;
            SEL_WRAP: rd_mux[WRAP_W-1:0] = cfg.wrap;
            SEL_DONE: rd_mux[0]          = done_sync;
            default:  rd_mux = '0;
        endcase
    end

    // Register the read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (rd_fire) rdata <= rd_mux;
    end

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(rdata));

    // R5
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && sel == SEL_NONE) |=> (rdata == '0));

    // R3
    ctrl_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_fire && sel == SEL_CTRL) |=> ($stable(ctrl_rst) && $stable(ctrl_go)));

    // R4
    cfg_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(cfg) && $stable(cfg_tgl)));

    // R2
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && sel == SEL_ID) |=> (rdata == ID_VALUE));
endmodule

// File: rtl/csr_cdc_bank.sv
// Module: csr_cdc_bank (top)
// Bus-domain register bank with synchronized paths to and from the
// faster engine domain: control bits and the configuration bundle go
// forward, and the completion flag comes back.
// Assumes: eng_clk runs faster than bus_clk; the host sets the
// configuration before it raises the run enable in a later bus cycle.
// Reset: one synchronous active-low reset per domain.
module csr_cdc_bank
    import csr_cdc_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter logic [31:0] ID_VALUE    = 32'h5C5B_0001,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_clk,
    input  logic              eng_rst_n,
    input  logic              eng_done,
    output logic              eng_reset,
    output logic              eng_go,
    output logic [11:0]       eng_blk_len,
    output logic [11:0]       eng_iter_cnt,
    output logic [15:0]       eng_wrap_addr
);
    localparam int NUM_CTRL = 2;

    logic                done_sync;
    logic                ctrl_rst;
    logic                ctrl_go;
    cfg_t                cfg_bus;
    cfg_t                cfg_eng;
    logic                cfg_tgl;
    logic [NUM_CTRL-1:0] ctrl_src;
    logic [NUM_CTRL-1:0] ctrl_dst;

    csr_regs #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_regs (
        .clk       (bus_clk),
        .rst_n     (bus_rst_n),
        .en        (bus_en),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .done_sync (done_sync),
        .ctrl_rst  (ctrl_rst),
        .ctrl_go   (ctrl_go),
        .cfg       (cfg_bus),
        .cfg_tgl   (cfg_tgl)
    );

    assign ctrl_src = {ctrl_go, ctrl_rst};

    // One level synchronizer per control bit into the engine domain.
    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl_sync
        csr_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (eng_clk),
            .rst_n (eng_rst_n),
            .d     (ctrl_src[i]),
            .q     (ctrl_dst[i])
        );
    end

    assign eng_reset = ctrl_dst[0];
    assign eng_go    = ctrl_dst[1];

    csr_cfg_sync #(.W(CFG_W), .SYNC_STAGES(SYNC_STAGES)) u_cfg_sync (
        .dst_clk   (eng_clk),
        .dst_rst_n (eng_rst_n),
        .src_data  (cfg_bus),
        .src_tgl   (cfg_tgl),
        .dst_data  (cfg_eng)
    );

    assign eng_blk_len   = cfg_eng.blk;
    assign eng_iter_cnt  = cfg_eng.iter;
    assign eng_wrap_addr = cfg_eng.wrap;

    // Completion flag back into the bus domain.
    csr_sync_bit #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk   (bus_clk),
        .rst_n (bus_rst_n),
        .d     (eng_done),
        .q     (done_sync)
    );

    // R10
    ctrl_reset_chk: assert property (@(posedge eng_clk)
        !eng_rst_n |=> (!eng_reset && !eng_go));
endmodule

// File: tb/csr_cdc_bank_test.sv
module csr_cdc_bank_test;
    logic        bus_clk = 1'b0;
    logic        eng_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        eng_rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_done = 1'b0;
    logic        eng_reset, eng_go;
    logic [11:0] eng_blk_len, eng_iter_cnt;
    logic [15:0] eng_wrap_addr;

    localparam logic [31:0] IDV = 32'h5C5B_0001;

    int checks = 0;
    int errors = 0;

    // shadow model of the register contents
    logic        m_rst, m_go;
    logic [11:0] m_blk, m_iter;
    logic [15:0] m_wrap;
    logic        m_done;

    always #10  bus_clk = ~bus_clk;
    always #2.5 eng_clk = ~eng_clk;

    csr_cdc_bank uut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_clk(eng_clk), .eng_rst_n(eng_rst_n), .eng_done(eng_done),
        .eng_reset(eng_reset), .eng_go(eng_go), .eng_blk_len(eng_blk_len),
        .eng_iter_cnt(eng_iter_cnt), .eng_wrap_addr(eng_wrap_addr)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00:   return IDV;
            8'h04:   return {27'd0, m_go, 3'd0, m_rst};
            8'h08:   return {20'd0, m_blk};
            8'h0C:   return {20'd0, m_iter};
            8'h10:   return {16'd0, m_wrap};
            8'h20:   return {31'd0, m_done};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h04: begin m_rst = d[0]; m_go = d[4]; end
            8'h08: m_blk  = d[11:0];
            8'h0C: m_iter = d[11:0];
            8'h10: m_wrap = d[15:0];
            default: ;
        endcase
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a bus_clk negedge; returns at the next negedge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        model_write(a, d);
        @(negedge bus_clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge bus_clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_check(input logic [7:0] a, input string req);
        logic [31:0] r;
        logic [31:0] e;
        e = exp_read(a);
        bus_read(a, r);
        check(r == e, req, r, e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge bus_clk);
    endtask

    task automatic eng_check(input string req);
        check({eng_reset, eng_go} == {m_rst, m_go}, "R7 ctrl",
              {30'd0, eng_reset, eng_go}, {30'd0, m_rst, m_go});
        check({eng_blk_len, eng_iter_cnt, eng_wrap_addr} == {m_blk, m_iter, m_wrap}, req,
              {eng_blk_len, eng_iter_cnt[11:4]}, {m_blk, m_iter[11:4]});
        check(eng_wrap_addr == m_wrap, req, {16'd0, eng_wrap_addr}, {16'd0, m_wrap});
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd7331));
        m_rst = 0; m_go = 0; m_blk = 0; m_iter = 0; m_wrap = 0; m_done = 0;
        idle(4);
        // R1 / R10: reset state with both resets held low
        check(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
        check({eng_reset, eng_go, eng_blk_len, eng_iter_cnt, eng_wrap_addr} == 0,
              "R10 eng outputs", {eng_blk_len, eng_iter_cnt, eng_wrap_addr[15:8]}, 0);
        bus_rst_n = 1'b1; eng_rst_n = 1'b1;
        idle(2);
        read_check(8'h04, "R1 ctrl");
        read_check(8'h08, "R1 blk");
        read_check(8'h10, "R1 wrap");

        // R2: identification and read-only offsets
        read_check(8'h00, "R2 id");
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h20, 32'hFFFF_FFFF);
        read_check(8'h00, "R2 id after write");
        read_check(8'h20, "R2 done after write");

        // R3: only bits 0 and 4 of the control word
        bus_write(8'h04, 32'hFFFF_FFFF);
        read_check(8'h04, "R3 ctrl all ones");
        bus_write(8'h04, 32'hFFFF_FFEE);
        read_check(8'h04, "R3 ctrl masked");

        // R4: field widths
        bus_write(8'h08, 32'hABCD_E123);
        bus_write(8'h0C, 32'h1234_5FED);
        bus_write(8'h10, 32'hDEAD_BEEF);
        read_check(8'h08, "R4 blk");
        read_check(8'h0C, "R4 iter");
        read_check(8'h10, "R4 wrap");

        // R5: unmapped offsets read zero and writes there are ignored
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_write(8'h24, 32'h0000_0FFF);
        read_check(8'h14, "R5 unmapped 0x14");
        read_check(8'hFC, "R5 unmapped 0xFC");
        read_check(8'h08, "R5 blk untouched");
        read_check(8'h04, "R5 ctrl untouched");

        // R6: data valid one cycle later and held while idle
        bus_read(8'h00, r);
        check(r == IDV, "R6 latency", r, IDV);
        bus_addr = 8'h14;
        idle(3);
        check(bus_rdata == IDV, "R6 hold", bus_rdata, IDV);

        // R7 / R8: engine side follows
        idle(2);
        eng_check("R8 bundle");
        bus_write(8'h04, 32'h0000_0010);
        idle(2);
        check(eng_go == 1'b1 && eng_reset == 1'b0, "R7 go only", {eng_reset, eng_go}, 2'b01);

        // R8: back-to-back bundle updates on consecutive bus cycles
        bus_en = 1'b1; bus_we = 1'b1;
        bus_addr = 8'h08; bus_wdata = 32'h0000_0040; model_write(8'h08, bus_wdata);
        @(negedge bus_clk);
        bus_addr = 8'h0C; bus_wdata = 32'h0000_0007; model_write(8'h0C, bus_wdata);
        @(negedge bus_clk);
        bus_addr = 8'h10; bus_wdata = 32'h0000_0100; model_write(8'h10, bus_wdata);
        @(negedge bus_clk);
        bus_en = 1'b0; bus_we = 1'b0;
        idle(2);
        eng_check("R8 back-to-back");

        // R9: completion flag crossing
        eng_done = 1'b1; m_done = 1'b1;
        idle(2);
        read_check(8'h20, "R9 done set");
        eng_done = 1'b0; m_done = 1'b0;
        idle(2);
        read_check(8'h20, "R9 done clear");

        // random traffic mixed over mapped and unmapped offsets
        for (int i = 0; i < 80; i++) begin
            logic [7:0] pool [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h20,
                                      8'h14, 8'h1C, 8'h24, 8'hFC};
            logic [7:0] a;
            a = pool[$urandom_range(0, 9)];
            if ($urandom_range(0, 1) == 1) bus_write(a, $urandom);
            else read_check(a, "R4 R5 random read");
            if (i % 10 == 9) begin
                idle(2);
                eng_check("R8 random");
            end
        end

        // R10: engine reset clears the engine outputs
        eng_rst_n = 1'b0;
        idle(1);
        check({eng_reset, eng_go, eng_blk_len, eng_iter_cnt, eng_wrap_addr} == 0,
              "R10 eng reset", {eng_blk_len, eng_iter_cnt, eng_wrap_addr[15:8]}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule